// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block serves a single 32-pin general-purpose I/O bank. Software reaches it through a simple word-wide register port. Each pin has an output data bit and an output enable, and its input is sampled through a synchronizer. Every pin can raise an interrupt. Three independent per-pin configuration bits choose how an interrupt is detected: level or edge, single or dual edge, and active polarity.

Edge events are latched in a raw status register. Level events track the synchronized pin level and are not latched. A mask gives a masked status view, and the masked bits are ORed into one registered interrupt line. Software clears latched edges by writing ones to a clear register. An edge that arrives in the same cycle as its clear is kept, so the usual flow of clearing a bit and then servicing it never loses an event. Multi-bank address decoding, pad pull and drive settings, and pin muxing sit outside this block.

Top module: `gpio_bank`

## Requirements
- R1: The register port decodes the word index `reg_addr_i[5:2]`, and only when `reg_addr_i[1:0]` is 0. A read returns its data on `reg_rdata_o` one cycle after the request. In all other cycles `reg_rdata_o` is 0. Reads of unmapped or unaligned addresses return 0, and writes to them change nothing.
- R2: The register at offset 0x04 holds the output data and drives `pin_o`. The register at 0x08 holds the output enable (1 = drive) and drives `pin_oe_o`. Both take a written value one cycle after the write and read back what was written.
- R3: A read of offset 0x00 returns the pin inputs after two synchronizer flops. A change on `pin_i` before clock edge k is visible to a read issued after edge k+1.
- R4: Offset 0x14 holds the polarity bits (1 = rising or high, 0 = falling or low). For a pin in edge mode (bit clear at 0x0C) with dual edge off, the raw status bit at 0x1C latches only on a synchronized transition in the selected direction.
- R5: When a pin's dual-edge bit at offset 0x10 is 1 in edge mode, both transitions latch its raw status, whatever its polarity bit holds.
- R6: A pin whose bit at offset 0x0C is 1 is in level mode. Its raw status is 1 exactly while its synchronized input equals its polarity bit. It is not latched, so a clear write has no lasting effect while the level stays asserted.
- R7: Offset 0x18 is the mask (1 = enabled). A read of offset 0x20 returns raw status AND mask. `irq_o` is the OR of these masked bits, registered one cycle.
- R8: Writing offset 0x24 clears each latched edge bit whose data bit is 1 and leaves bits written with 0 unchanged. An edge detected in the same cycle as its clear stays latched.
- R9: After reset, every register, status bit, `pin_o`, `pin_oe_o` and `irq_o` is 0. Reads of 0x24 return 0. Writes to offsets 0x00, 0x1C and 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin inputs |
| pin_o | output | 32 | Output data to the pads |
| pin_oe_o | output | 32 | Output enables to the pads |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 6 | Byte address within the bank |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after a read |
| irq_o | output | 1 | Registered OR of the masked status |

## Verification
The latencies, counted in clock edges after the stimulus, are as follows. Register reads, `pin_o` and `pin_oe_o` respond one edge after the access. A pin change reaches the input data register after two edges and level status after two edges. Edge status is latched on the third edge, and `irq_o` follows the status by one further edge. The reference model in the bench advances one state per clock through the same counted stages, and every output is compared one time unit after each rising edge. Coincident clear and edge timing comes from sweeping the clear write across every offset relative to the pin toggle, so that one of the offsets must land in the detection cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [3:0] {
    REG_DIN    = 4'd0,
    REG_DOUT   = 4'd1,
    REG_OE     = 4'd2,
    REG_LVL    = 4'd3,
    REG_BOTH   = 4'd4,
    REG_ACT_HI = 4'd5,
    REG_MASK   = 4'd6,
    REG_RAW    = 4'd7,
    REG_PEND   = 4'd8,
    REG_CLR    = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int k = 1; k <= STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] both_i,
  input  logic [WIDTH-1:0] act_hi_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] rise, fall, hit, lat_q;

  assign rise = sync_i & ~prev_i;
  assign fall = ~sync_i & prev_i;

  always_comb begin
    hit = (both_i & (rise | fall))
        | (~both_i & act_hi_i & rise)
        | (~both_i & ~act_hi_i & fall);
    hit = hit & ~lvl_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= (lat_q & ~clr_i) | hit;
  end

  assign raw_o = (lvl_i & ~(sync_i ^ act_hi_i)) | (~lvl_i & lat_q);

  AST_EDGE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((lat_q & $past(hit)) == $past(hit))); // R8
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~hit) != '0) |=> ((lat_q & $past(clr_i & ~hit)) == '0)); // R8
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  sync_i,
  input  logic [WIDTH-1:0]  raw_i,
  output logic [WIDTH-1:0]  dout_o,
  output logic [WIDTH-1:0]  oe_o,
  output logic [WIDTH-1:0]  lvl_o,
  output logic [WIDTH-1:0]  both_o,
  output logic [WIDTH-1:0]  act_hi_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  clr_o
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]    widx;
  logic             aligned, wr_en, rd_en;
  logic [WIDTH-1:0] dout_q, oe_q, lvl_q, both_q, act_hi_q, mask_q;
  logic [WIDTH-1:0] rd_mux, rdata_q;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_en   = req_i & we_i & aligned;
  assign rd_en   = req_i & ~we_i & aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      oe_q     <= '0;
      lvl_q    <= '0;
      both_q   <= '0;
      act_hi_q <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      case (widx)
        IW'(REG_DOUT):   dout_q   <= wdata_i;
        IW'(REG_OE):     oe_q     <= wdata_i;
        IW'(REG_LVL):    lvl_q    <= wdata_i;
        IW'(REG_BOTH):   both_q   <= wdata_i;
        IW'(REG_ACT_HI): act_hi_q <= wdata_i;
        IW'(REG_MASK):   mask_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (widx)
      IW'(REG_DIN):    rd_mux = sync_i;
      IW'(REG_DOUT):   rd_mux = dout_q;
      IW'(REG_OE):     rd_mux = oe_q;
      IW'(REG_LVL):    rd_mux = lvl_q;
      IW'(REG_BOTH):   rd_mux = both_q;
      IW'(REG_ACT_HI): rd_mux = act_hi_q;
      IW'(REG_MASK):   rd_mux = mask_q;
      IW'(REG_RAW):    rd_mux = raw_i;
      IW'(REG_PEND):   rd_mux = raw_i & mask_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
    else            rdata_q <= '0;
  end

  assign clr_o    = (wr_en && widx == IW'(REG_CLR)) ? wdata_i : '0;
  assign rdata_o  = rdata_q;
  assign dout_o   = dout_q;
  assign oe_o     = oe_q;
  assign lvl_o    = lvl_q;
  assign both_o   = both_q;
  assign act_hi_o = act_hi_q;
  assign mask_o   = mask_q;

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && widx == IW'(REG_DOUT)) |=> $stable(dout_o)); // R2
  AST_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && widx == IW'(REG_CLR)) |=> (rdata_o == '0)); // R9
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> (rdata_o == '0)); // R1
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] sync_v, prev_v, raw_v, masked_v;
  logic [WIDTH-1:0] lvl_v, both_v, act_hi_v, mask_v, clr_v;
  logic             irq_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .async_i(pin_i), .sync_o(sync_v), .prev_o(prev_v)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) i_detect (
    .clk_i, .rst_ni,
    .sync_i(sync_v), .prev_i(prev_v),
    .lvl_i(lvl_v), .both_i(both_v), .act_hi_i(act_hi_v),
    .clr_i(clr_v), .raw_o(raw_v)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .sync_i(sync_v), .raw_i(raw_v),
    .dout_o(pin_o), .oe_o(pin_oe_o),
    .lvl_o(lvl_v), .both_o(both_v), .act_hi_o(act_hi_v),
    .mask_o(mask_v), .clr_o(clr_v)
  );

  assign masked_v = raw_v & mask_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked_v;
  end

  assign irq_o = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_v & mask_v) == '0) |=> !irq_o); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_v & mask_v) != '0) |=> irq_o); // R7
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pin_o, pin_oe_o, rdata;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_s1 = '0, m_s2 = '0, m_pv = '0, m_lat = '0;
  logic [31:0] m_dout = '0, m_oe = '0, m_lvl = '0, m_both = '0, m_pol = '0, m_msk = '0;
  logic [31:0] m_rd = '0;
  logic        m_irq = 1'b0;
  string       m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R3";
      1, 2: return "R2";
      3: return "R6";
      4: return "R5";
      5, 7: return "R4";
      6, 8: return "R7";
      9: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] raw_now();
    logic [31:0] r;
    for (int b = 0; b < 32; b++)
      r[b] = m_lvl[b] ? (m_s2[b] == m_pol[b]) : m_lat[b];
    return r;
  endfunction

  task automatic step();
    logic [31:0] raw, hit, clr, rd_v;
    logic [31:0] n_dout, n_oe, n_lvl, n_both, n_pol, n_msk, p;
    bit aligned;
    int idx;
    string tg;
    raw = raw_now();
    for (int b = 0; b < 32; b++) begin
      hit[b] = 1'b0;
      if (!m_lvl[b] && m_s2[b] != m_pv[b])
        hit[b] = m_both[b] || (m_s2[b] == m_pol[b]);
    end
    aligned = (addr[1:0] == 2'b00);
    idx = int'(addr[5:2]);
    clr = (req && we && aligned && idx == 9) ? wdata : '0;
    rd_v = '0;
    tg = "R1";
    if (req && !we && aligned) begin
      tg = tag_of(idx);
      case (idx)
        0: rd_v = m_s2;
        1: rd_v = m_dout;
        2: rd_v = m_oe;
        3: rd_v = m_lvl;
        4: rd_v = m_both;
        5: rd_v = m_pol;
        6: rd_v = m_msk;
        7: rd_v = raw;
        8: rd_v = raw & m_msk;
        default: rd_v = '0;
      endcase
    end
    n_dout = m_dout; n_oe = m_oe; n_lvl = m_lvl; n_both = m_both; n_pol = m_pol; n_msk = m_msk;
    if (req && we && aligned) begin
      case (idx)
        1: n_dout = wdata;
        2: n_oe = wdata;
        3: n_lvl = wdata;
        4: n_both = wdata;
        5: n_pol = wdata;
        6: n_msk = wdata;
        default: ;
      endcase
    end
    p = pin;
    @(posedge clk);
    m_pv = m_s2; m_s2 = m_s1; m_s1 = p;
    m_lat = (m_lat & ~clr) | hit;
    m_irq = |(raw & m_msk);
    m_rd = rd_v; m_tag = tg;
    m_dout = n_dout; m_oe = n_oe; m_lvl = n_lvl; m_both = n_both; m_pol = n_pol; m_msk = n_msk;
    #1;
    chk("R2", "pin_o", pin_o, m_dout);
    chk("R2", "pin_oe_o", pin_oe_o, m_oe);
    chk("R7", "irq_o", {31'b0, irq}, {31'b0, m_irq});
    chk(m_tag, "reg_rdata_o", rdata, m_rd);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    step();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a);
    req = 1'b1; we = 1'b0; addr = a;
    step();
    req = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R9: reset values, R1: unmapped
    for (int a = 0; a <= 15; a++) rd(6'(a * 4));
    // R2: output data and enable
    wr(6'h04, 32'hA5A5_0F0F);
    wr(6'h08, 32'hFFFF_0000);
    rd(6'h04); rd(6'h08);
    // R9: read-only registers ignore writes
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h1C, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h00); rd(6'h1C); rd(6'h20); rd(6'h24);
    // R1: unaligned ignored
    wr(6'h05, 32'h1234_5678); rd(6'h04); rd(6'h06); rd(6'h3C);
    // R3: synchronizer
    pin = 32'h1234_5678;
    rd(6'h00); rd(6'h00); rd(6'h00); rd(6'h00);
    pin = '0; idle(4);
    // config: 0-7 rising, 8-15 falling, 16-23 dual, 24-27 level high, 28-31 level low
    wr(6'h0C, 32'hFF00_0000);
    wr(6'h10, 32'h00FF_0000);
    wr(6'h14, 32'h0FF0_00FF);
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    idle(2); rd(6'h1C); rd(6'h20);
    // R4: rising and falling single edge
    pin = 32'h0000_0101; idle(4); rd(6'h1C); rd(6'h20);
    wr(6'h24, 32'h0000_0101); rd(6'h1C);
    pin = 32'h0000_0000; idle(4); rd(6'h1C);
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h1C);
    // R5: dual edge both ways
    pin = 32'h00FF_0000; idle(4); rd(6'h1C);
    wr(6'h24, 32'h00FF_0000);
    pin = 32'h0000_0000; idle(4); rd(6'h1C);
    wr(6'h24, 32'h00FF_0000); rd(6'h1C);
    // R8: clear swept across the detection cycle; partial clear keeps others
    for (int k = 0; k < 5; k++) begin
      pin = pin ^ 32'h0001_0001;
      idle(k);
      wr(6'h24, 32'h0001_0001);
      idle(3); rd(6'h1C);
      wr(6'h24, 32'hFFFF_FFFF);
    end
    // R6: level mode not latched
    pin = 32'h0100_0000; idle(3); rd(6'h1C);
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h1C);
    pin = 32'hF000_0000; idle(3); rd(6'h1C);
    // R7: masking
    wr(6'h18, 32'h0000_0000); idle(2); rd(6'h20);
    wr(6'h18, 32'h1000_0000); idle(2); rd(6'h20);
    pin = '0; idle(3);
    wr(6'h18, 32'hFFFF_FFFF);
    // mixed pseudo-random traffic
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) pin = lfsr;
      case (lfsr[7:5])
        3'd0: wr(6'h24, lfsr ^ 32'h5A5A_A5A5);
        3'd1: rd(6'h1C);
        3'd2: rd(6'h20);
        3'd3: rd(6'h00);
        3'd4: if (lfsr[9:8] == 2'b00) wr(6'({lfsr[11:10] + 2'd1, 2'b00} + 6'h08), lfsr);
              else step();
        default: step();
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule